// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Sequencer

This block runs whole-bank maintenance on a byte-wide flash device that only accepts commands after a two-write unlock handshake at fixed offsets. A single request starts one of two jobs on a bank whose base address comes with the request. An erase sends the unlock, an erase arm code, a second unlock and the erase code. A program job repeats the unlock, the program code and the data byte once for every byte in the bank, and it fetches each byte from a caller-owned buffer through a combinational read port.

The device shows that an internal operation is still running by returning different values on back-to-back reads. After each command the sequencer reads the bank base in pairs until one pair returns the same value twice. It gives up after a configurable number of pairs. At the end of the job it always sends the device its reset code. If no timeout occurred, it then reads the bank back and compares each byte with 0xFF after an erase, or with the buffer after programming. `busy`, a one-cycle `done` and a sticky `error` report the result.

A fixed idle spacing is kept between every two bus operations, reads included, so that a slow device sees its minimum write-to-write time.

Top module: `flash_bank_seq`

## Requirements
- R1: After reset `busy`, `done`, `error` and `bus_req` are all low, and `bus_req` is never high while `busy` is low.
- R2: An erase issues exactly these writes, in this order: 0xAA to base+0x555, 0x55 to base+0x2AA, 0x80 to base+0x555, 0xAA to base+0x555, 0x55 to base+0x2AA, 0x30 to base.
- R3: A program job handles bytes 0 to NBYTES-1 in ascending order. For byte i it writes 0xAA to base+0x555, 0x55 to base+0x2AA, 0xA0 to base+0x555 and then `buf_data` (read with `buf_addr`=i) to base+i.
- R4: Any two bus operations (`bus_req` high, read or write) are separated by at least GAP_CYCLES cycles in which `bus_req` is low.
- R5: After the last command write of an erase, or of each programmed byte, the block reads base in pairs. It continues with the job once both reads of a pair return the same value.
- R6: If POLL_LIMIT pairs in a row differ, `error` is raised, no further byte is programmed and no read-back is done.
- R7: Every job, including one that timed out, ends with one write of 0xF0 to base.
- R8: After the reset write of a job without timeout, the block reads base+i for ascending i. It compares each value with 0xFF (erase) or with `buf_data` (program), raises `error` and stops at the first mismatch.
- R9: `busy` goes high in the cycle after a request is accepted. `done` is high for exactly one cycle, which is the cycle in which `busy` has just dropped.
- R10: `error` keeps its value while the block is idle. It is cleared when the next request is accepted.
- R11: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a job (accepted when idle) |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_base | input | ADDR_W | Bank base address |
| buf_addr | output | IDX_W | Byte index into the source buffer |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| bus_req | output | 1 | Bus operation strobe, one cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished, one-cycle pulse |
| error | output | 1 | Last job timed out or failed verification |

## Verification
The checker watches, on every cycle, the spacing between bus strobes, that the bus is quiet while idle, the shape of the done pulse, and that the error flag holds while idle and clears on acceptance. The command order, the number of poll pairs before the reset write, the abort of the remaining bytes after a timeout, the length of the read-back and the stop at the first mismatch depend on how the device answers. These can only be shown by the bench's flash stub, which models toggling, stuck and corrupting devices, together with the scoreboard of expected writes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    // Offsets and codes decoded by the flash device
    localparam logic [11:0] OFF_UNLOCK_A = 12'h555;
    localparam logic [11:0] OFF_UNLOCK_B = 12'h2AA;
    localparam logic [7:0]  CODE_KEY_A   = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B   = 8'h55;
    localparam logic [7:0]  CODE_ERS_ARM = 8'h80;
    localparam logic [7:0]  CODE_ERS_GO  = 8'h30;
    localparam logic [7:0]  CODE_PGM     = 8'hA0;
    localparam logic [7:0]  CODE_RESET   = 8'hF0;
    localparam logic [7:0]  ERASED_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL_A,
        ST_POLL_B,
        ST_POLL_CHK,
        ST_RESET,
        ST_VRD,
        ST_VCHK,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int OFF_W = 13
) (
    input  logic             is_erase,
    input  logic [2:0]       step,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    output logic [OFF_W-1:0] off,
    output logic [7:0]       wdata,
    output logic             last
);

    always_comb begin
        off   = '0;
        wdata = '0;
        last  = 1'b0;
        if (is_erase) begin
            case (step)
                3'd0: begin off = OFF_W'(OFF_UNLOCK_A); wdata = CODE_KEY_A;   end
                3'd1: begin off = OFF_W'(OFF_UNLOCK_B); wdata = CODE_KEY_B;   end
                3'd2: begin off = OFF_W'(OFF_UNLOCK_A); wdata = CODE_ERS_ARM; end
                3'd3: begin off = OFF_W'(OFF_UNLOCK_A); wdata = CODE_KEY_A;   end
                3'd4: begin off = OFF_W'(OFF_UNLOCK_B); wdata = CODE_KEY_B;   end
                default: begin off = '0; wdata = CODE_ERS_GO; last = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0: begin off = OFF_W'(OFF_UNLOCK_A); wdata = CODE_KEY_A; end
                3'd1: begin off = OFF_W'(OFF_UNLOCK_B); wdata = CODE_KEY_B; end
                3'd2: begin off = OFF_W'(OFF_UNLOCK_A); wdata = CODE_PGM;   end
                default: begin off = OFF_W'(idx); wdata = data; last = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/flash_gap_timer.sv
module flash_gap_timer #(
    parameter int GAP_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ready
);

    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (fire)
            cnt_d = GW'(GAP_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/flash_rd_pair.sv
module flash_rd_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_strobe,
    input  logic [7:0] rdata,
    output logic [7:0] last,
    output logic       same
);

    typedef struct packed {
        logic       pend;
        logic [7:0] prev;
        logic [7:0] last;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.pend = rd_strobe;
        if (cap_q.pend) begin
            cap_d.prev = cap_q.last;
            cap_d.last = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign last = cap_q.last;
    assign same = (cap_q.prev == cap_q.last);

endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NBYTES     = 8192,
    parameter int GAP_CYCLES = 100,
    parameter int POLL_LIMIT = 1000000,
    localparam int IDX_W     = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_base,
    output logic [IDX_W-1:0]  buf_addr,
    input  logic [7:0]        buf_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              error
);

    localparam int OFF_W = (IDX_W > 12) ? IDX_W : 12;
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NBYTES - 1);
    localparam logic [TRY_W-1:0] LAST_TRY  = TRY_W'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              erase;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [2:0]        step;
        logic [TRY_W-1:0]  tries;
        logic              err;
        logic              timed_out;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             gap_ready;
    logic             rd_strobe;
    logic [7:0]       rd_last;
    logic             rd_same;
    logic [OFF_W-1:0] cmd_off;
    logic [7:0]       cmd_wdata;
    logic             cmd_last;

    flash_cmd_rom #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_rom (
        .is_erase (ctl_q.erase),
        .step     (ctl_q.step),
        .idx      (ctl_q.idx),
        .data     (buf_data),
        .off      (cmd_off),
        .wdata    (cmd_wdata),
        .last     (cmd_last)
    );

    flash_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (bus_req),
        .ready (gap_ready)
    );

    flash_rd_pair u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .rdata     (bus_rdata),
        .last      (rd_last),
        .same      (rd_same)
    );

    always_comb begin
        ctl_d     = ctl_q;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = ctl_q.base;
        bus_wdata = '0;
        done      = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st        = ST_CMD;
                    ctl_d.erase     = req_erase;
                    ctl_d.base      = req_base;
                    ctl_d.idx       = '0;
                    ctl_d.step      = '0;
                    ctl_d.tries     = '0;
                    ctl_d.err       = 1'b0;
                    ctl_d.timed_out = 1'b0;
                end
            end
            ST_CMD: begin
                if (gap_ready) begin
                    bus_req   = 1'b1;
                    bus_we    = 1'b1;
                    bus_addr  = ctl_q.base + ADDR_W'(cmd_off);
                    bus_wdata = cmd_wdata;
                    if (cmd_last) begin
                        ctl_d.st    = ST_POLL_A;
                        ctl_d.step  = '0;
                        ctl_d.tries = '0;
                    end else begin
                        ctl_d.step = ctl_q.step + 3'd1;
                    end
                end
            end
            ST_POLL_A: begin
                if (gap_ready) begin
                    bus_req  = 1'b1;
                    ctl_d.st = ST_POLL_B;
                end
            end
            ST_POLL_B: begin
                if (gap_ready) begin
                    bus_req  = 1'b1;
                    ctl_d.st = ST_POLL_CHK;
                end
            end
            ST_POLL_CHK: begin
                if (gap_ready) begin
                    if (rd_same) begin
                        if (ctl_q.erase || ctl_q.idx == LAST_IDX) begin
                            ctl_d.st = ST_RESET;
                        end else begin
                            ctl_d.idx = ctl_q.idx + 1'b1;
                            ctl_d.st  = ST_CMD;
                        end
                    end else if (ctl_q.tries == LAST_TRY) begin
                        ctl_d.err       = 1'b1;
                        ctl_d.timed_out = 1'b1;
                        ctl_d.st        = ST_RESET;
                    end else begin
                        ctl_d.tries = ctl_q.tries + 1'b1;
                        ctl_d.st    = ST_POLL_A;
                    end
                end
            end
            ST_RESET: begin
                if (gap_ready) begin
                    bus_req   = 1'b1;
                    bus_we    = 1'b1;
                    bus_wdata = CODE_RESET;
                    ctl_d.idx = '0;
                    ctl_d.st  = ctl_q.timed_out ? ST_FINISH : ST_VRD;
                end
            end
            ST_VRD: begin
                if (gap_ready) begin
                    bus_req  = 1'b1;
                    bus_addr = ctl_q.base + ADDR_W'(ctl_q.idx);
                    ctl_d.st = ST_VCHK;
                end
            end
            ST_VCHK: begin
                if (gap_ready) begin
                    if (rd_last != (ctl_q.erase ? ERASED_BYTE : buf_data)) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_FINISH;
                    end else if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st = ST_FINISH;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.st  = ST_VRD;
                    end
                end
            end
            ST_FINISH: begin
                done     = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_strobe = bus_req && !bus_we;
    assign buf_addr  = ctl_q.idx;
    assign busy      = (ctl_q.st != ST_IDLE) && (ctl_q.st != ST_FINISH);
    assign error     = ctl_q.err;

endmodule

// File: rtl/flash_bank_seq_chk.sv
module flash_bank_seq_chk #(
    parameter int GAP_CYCLES = 100
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic bus_req,
    input logic busy,
    input logic done,
    input logic error
);

    localparam int GW = $clog2(GAP_CYCLES + 1);

    logic [GW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       since_q <= GW'(GAP_CYCLES);
        else if (bus_req)                 since_q <= '0;
        else if (since_q != GW'(GAP_CYCLES)) since_q <= since_q + 1'b1;
    end

    // R4
    gap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> since_q == GW'(GAP_CYCLES));

    // R1
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R9
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> $stable(error));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !done) |=> (!error && busy));

endmodule

bind flash_bank_seq flash_bank_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_req   (bus_req),
    .busy      (busy),
    .done      (done),
    .error     (error)
);

// File: tb/sim_flash_bank_seq.sv
module sim_flash_bank_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int NBYTES     = 16;
    localparam int GAP        = 2;
    localparam int LIMIT      = 5;
    localparam int IDX_W      = $clog2(NBYTES);
    localparam logic [15:0] BASE = 16'h4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_erase = 1'b0;
    logic [ADDR_W-1:0] req_base = BASE;
    logic [IDX_W-1:0]  buf_addr;
    logic [7:0]        buf_data;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata = 8'h00;
    logic              busy, done, error;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_bank_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .GAP_CYCLES(GAP),
                     .POLL_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_base(req_base), .buf_addr(buf_addr), .buf_data(buf_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .done(done), .error(error)
    );

    // Source buffer
    logic [7:0] bufmem [NBYTES];
    assign buf_data = bufmem[buf_addr];

    // Flash stub
    logic [7:0] mem [NBYTES];
    int  busy_n = 0;
    bit  half = 0, tog = 0, stuck = 0, prog_arm = 0, erase_arm = 0;
    int  corrupt_idx = -1;
    int  off;

    always @(posedge clk) begin
        if (rst_n && bus_req) begin
            off = int'(bus_addr) - int'(BASE);
            if (bus_we) begin
                if (prog_arm) begin
                    if (off >= 0 && off < NBYTES)
                        mem[off] <= mem[off] & (bus_wdata ^ ((off == corrupt_idx) ? 8'h01 : 8'h00));
                    prog_arm <= 0; busy_n <= 3; half <= 0;
                end else if (off == 0 && bus_wdata == 8'hF0) begin
                    busy_n <= 0; erase_arm <= 0;
                end else if (off == 'h555 && bus_wdata == 8'hA0) begin
                    prog_arm <= 1;
                end else if (off == 'h555 && bus_wdata == 8'h80) begin
                    erase_arm <= 1;
                end else if (off == 0 && bus_wdata == 8'h30 && erase_arm) begin
                    for (int k = 0; k < NBYTES; k++) mem[k] <= 8'hFF;
                    erase_arm <= 0; busy_n <= 3; half <= 0;
                end
            end else begin
                if (busy_n > 0) begin
                    bus_rdata <= tog ? 8'h44 : 8'h04;
                    tog  <= ~tog;
                    half <= ~half;
                    if (half && !stuck) busy_n <= busy_n - 1;
                end else begin
                    bus_rdata <= (off >= 0 && off < NBYTES) ? mem[off] : 8'hFF;
                end
            end
        end
    end

    // Scoreboard
    typedef struct {
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_cyc = 0, min_gap = 1000;
    bit have_last = 0;
    int reads_since_cmd = 0, polls_at_rst = -1, reads_after_rst = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_w(input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && bus_req) begin
            if (have_last && (cyc - last_cyc) < min_gap) min_gap = cyc - last_cyc;
            last_cyc = cyc; have_last = 1;
            if (bus_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2/R3 unexpected write", int'(bus_addr), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(bus_addr == e.a, {e.tag, " write address"}, int'(bus_addr), int'(e.a));
                    chk(bus_wdata == e.d, {e.tag, " write data"}, int'(bus_wdata), int'(e.d));
                    if (e.tag == "R7") begin
                        polls_at_rst = reads_since_cmd;
                        reads_after_rst = 0;
                    end else begin
                        reads_since_cmd = 0;
                    end
                end
            end else begin
                reads_since_cmd++;
                reads_after_rst++;
            end
        end
    end

    task automatic push_erase();
        push_w(BASE + 16'h555, 8'hAA, "R2");
        push_w(BASE + 16'h2AA, 8'h55, "R2");
        push_w(BASE + 16'h555, 8'h80, "R2");
        push_w(BASE + 16'h555, 8'hAA, "R2");
        push_w(BASE + 16'h2AA, 8'h55, "R2");
        push_w(BASE,           8'h30, "R2");
        push_w(BASE,           8'hF0, "R7");
    endtask

    task automatic push_prog(input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            push_w(BASE + 16'h555, 8'hAA, "R3");
            push_w(BASE + 16'h2AA, 8'h55, "R3");
            push_w(BASE + 16'h555, 8'hA0, "R3");
            push_w(BASE + 16'(i), bufmem[i], "R3");
        end
        push_w(BASE, 8'hF0, "R7");
    endtask

    task automatic run_op(input bit erase, input bit probe_ignore);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_erase = erase; req_base = BASE;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        chk(error == 1'b0, "R10 error cleared on accept", int'(error), 0);
        if (probe_ignore) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1; req_erase = ~erase; req_base = BASE + 16'h100;
            @(negedge clk);
            req_valid = 1'b0; req_base = BASE;
            chk(busy == 1'b1, "R11 busy kept during ignored request", int'(busy), 1);
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done seen", int'(done), 1);
        chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chk(exp_q.size() == 0, "R2/R3 all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic check_mem_erased(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[i] != 8'hFF) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) begin
            mem[i] = 8'h00;
            bufmem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && bus_req == 0,
            "R1 reset outputs", {busy, done, error, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && bus_req == 0,
            "R1 idle after reset", {busy, done, error, bus_req}, 0);

        // Erase, with an ignored request in the middle
        push_erase();
        run_op(1'b1, 1'b1);
        chk(error == 0, "R8 erase verify ok", int'(error), 0);
        chk(polls_at_rst == 8, "R5 erase poll reads", polls_at_rst, 8);
        chk(reads_after_rst == NBYTES, "R8 erase read-back length", reads_after_rst, NBYTES);
        check_mem_erased("R2 bank erased");

        // Program pattern A
        push_prog(NBYTES);
        run_op(1'b0, 1'b0);
        chk(error == 0, "R8 program verify ok", int'(error), 0);
        chk(polls_at_rst == 8, "R5 program poll reads", polls_at_rst, 8);
        chk(reads_after_rst == NBYTES, "R8 program read-back length", reads_after_rst, NBYTES);
        for (int i = 0; i < NBYTES; i++)
            chk(mem[i] == 8'(i * 7 + 3), "R3 programmed byte A", int'(mem[i]), i * 7 + 3);

        // Erase then program pattern B
        push_erase();
        run_op(1'b1, 1'b0);
        for (int i = 0; i < NBYTES; i++) bufmem[i] = ~8'(i * 16 + i);
        push_prog(NBYTES);
        run_op(1'b0, 1'b0);
        chk(error == 0, "R8 program B verify ok", int'(error), 0);
        for (int i = 0; i < NBYTES; i++)
            chk(mem[i] == bufmem[i], "R3 programmed byte B", int'(mem[i]), int'(bufmem[i]));

        // Verify mismatch on byte 3
        push_erase();
        run_op(1'b1, 1'b0);
        corrupt_idx = 3;
        push_prog(NBYTES);
        run_op(1'b0, 1'b0);
        corrupt_idx = -1;
        chk(error == 1, "R8 mismatch raises error", int'(error), 1);
        chk(reads_after_rst == 4, "R8 read-back stops at mismatch", reads_after_rst, 4);

        // Error held while idle
        repeat (20) @(negedge clk);
        chk(error == 1, "R10 error held while idle", int'(error), 1);

        // Erase clears error (checked on accept inside run_op)
        push_erase();
        run_op(1'b1, 1'b0);
        chk(error == 0, "R10 error cleared by next job", int'(error), 0);

        // Timeout on byte 0 of a program job
        stuck = 1;
        push_prog(1);
        exp_q.delete(exp_q.size() - 1);
        push_w(BASE, 8'hF0, "R7");
        run_op(1'b0, 1'b0);
        stuck = 0;
        chk(error == 1, "R6 timeout raises error", int'(error), 1);
        chk(polls_at_rst == 2 * LIMIT, "R6 poll pairs before give-up", polls_at_rst, 2 * LIMIT);
        repeat (4) @(negedge clk);
        chk(reads_after_rst == 0, "R6 no read-back after timeout", reads_after_rst, 0);

        chk(min_gap >= GAP + 1, "R4 minimum strobe spacing", min_gap, GAP + 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule